// File: doc/BRIEF.md
# Flash Converter Thermometer-to-Binary Encoder

This block is the digital back end of an eight-comparator flash converter. On every system clock edge it registers the comparator bank's thermometer word into an input latch. On the following edge it registers a binary level code built from that word. A full-scale input, where every comparator reads high, is reported as binary zero with a separate overflow bit raised. The result is four bits wide: overflow plus a three-bit binary value.

Two encodings are offered, and an `enc_mode` input selects between them. It is captured on the same edge as the comparator word. The counting encoding takes the number of ones in the latched word. This absorbs isolated bubbles, which are comparators that disagree with their neighbours. The strict encoding takes the position of the highest set comparator. In strict mode, a malformed word sets a sticky error flag, which only reset clears. A lifecycle state machine moves from `LC_WARM`, entered on reset, to `LC_LIVE` on the first clock edge after reset is released, and it stays there. `valid_out` is high in `LC_LIVE`. A second state machine moves from `EF_CLEAN` to `EF_FLAGGED` when a strict-mode bubble is found. `EF_FLAGGED` has no exit other than reset.

Top module: `flash_therm_enc`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high, `bin_out`, `ovf_out`, `valid_out` and `bubble_err` all become 0 on that edge.
- R2: `valid_out` rises on the first clock edge at which `rst` is sampled low, and it then stays high until the next reset.
- R3: The word on `therm_in` sampled at edge k appears on `bin_out`/`ovf_out` after edge k+1, which is two edges of latency.
- R4: A proper thermometer word with n low-order ones (0 ≤ n ≤ 7) and zeros above yields `bin_out` = n and `ovf_out` = 0, in both modes.
- R5: The all-ones word yields `bin_out` = 0 and `ovf_out` = 1, in both modes.
- R6: In counting mode (`enc_mode` = 0), the level is the number of ones in the word, including words with bubbles. A level of 8 is reported as in R5.
- R7: In strict mode (`enc_mode` = 1), the level is one plus the bit index of the highest set bit, or 0 when no bit is set. Whenever bit 7 is set, the result is therefore `ovf_out` = 1 with `bin_out` = 0.
- R8: In strict mode, a word with a 0 at some bit i-1 below a 1 at bit i sets `bubble_err`. The flag appears in the same output cycle as that word's result and remains set until reset.
- R9: Words with bubbles in counting mode have no effect on `bubble_err`.
- R10: `enc_mode` is captured together with `therm_in`, so changing the mode every cycle encodes each word under its own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the latch and output stage |
| rst | input | 1 | Synchronous active-high reset |
| therm_in | input | 8 | Comparator word; bit 0 is the lowest threshold |
| enc_mode | input | 1 | 0 selects counting, 1 selects strict encoding |
| bin_out | output | 3 | Binary level, modulo 8 |
| ovf_out | output | 1 | High when the level equals 8 |
| valid_out | output | 1 | High once the lifecycle state is `LC_LIVE` |
| bubble_err | output | 1 | Sticky strict-mode malformed-word flag |

## Verification
In strict mode, overflow and the bubble flag can both be raised by a single word. Any word whose top bit is set and that has a hole lower down, such as 10111111, reports overflow and sets the error in the same output cycle. The bench drives such words in strict mode and checks that the result and the flag land together. It also drives the same words in counting mode, where they must give an ordinary count with no flag. Mode toggling on consecutive cycles with an identical word separates the two outcomes cycle by cycle.

// File: rtl/fte_pkg.sv
package fte_pkg;

    // Encoding selector, captured with the comparator word.
    typedef enum logic {
        ENC_COUNT  = 1'b0,
        ENC_STRICT = 1'b1
    } enc_mode_e;

    // Output-stage lifecycle.
    typedef enum logic {
        LC_WARM = 1'b0,
        LC_LIVE = 1'b1
    } life_e;

    // Sticky malformed-word tracker.
    typedef enum logic {
        EF_CLEAN   = 1'b0,
        EF_FLAGGED = 1'b1
    } errst_e;

endpackage

// File: rtl/fte_capture.sv
module fte_capture
    import fte_pkg::*;
#(
    parameter int N_CMP = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_CMP-1:0] therm_in,
    input  logic             mode_in,
    output logic [N_CMP-1:0] code_q,
    output enc_mode_e        mode_q
);

    // Input latch on the system clock; word and mode travel together.
    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            mode_q <= ENC_COUNT;
        end else begin
            code_q <= therm_in;
            mode_q <= enc_mode_e'(mode_in);
        end
    end

endmodule

// File: rtl/fte_level_enc.sv
module fte_level_enc
    import fte_pkg::*;
#(
    parameter int N_CMP = 8,
    parameter int LVL_W = $clog2(N_CMP + 1)
) (
    input  logic [N_CMP-1:0] code,
    input  enc_mode_e        mode,
    output logic [LVL_W-1:0] level,
    output logic             bubble_hit
);

    // A hole is a set comparator sitting directly on a clear one.
    logic [N_CMP-1:0] hole_at;
    assign hole_at[0] = 1'b0;

    generate
        for (genvar g = 1; g < N_CMP; g++) begin : g_hole
            assign hole_at[g] = code[g] & ~code[g-1];
        end
    endgenerate

    logic [LVL_W-1:0] ones_cnt;
    logic [LVL_W-1:0] top_pos;

    // Population count: bubbles simply add or remove one unit.
    always_comb begin
        ones_cnt = '0;
        for (int i = 0; i < N_CMP; i++) begin
            ones_cnt = ones_cnt + LVL_W'(code[i]);
        end
    end

    // Highest set comparator, counted from one.
    always_comb begin
        top_pos = '0;
        for (int i = 0; i < N_CMP; i++) begin
            if (code[i]) begin
                top_pos = LVL_W'(i + 1);
            end
        end
    end

    always_comb begin
        level = ones_cnt;
        unique case (mode)
            ENC_COUNT:  level = ones_cnt;
            ENC_STRICT: level = top_pos;
        endcase
    end

    assign bubble_hit = (mode == ENC_STRICT) && (|hole_at);

endmodule

// File: rtl/fte_out_stage.sv
module fte_out_stage
    import fte_pkg::*;
#(
    parameter int N_CMP = 8,
    parameter int BIN_W = 3,
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] level,
    input  logic             bubble_hit,
    output logic [BIN_W-1:0] bin_out,
    output logic             ovf_out,
    output logic             valid_out,
    output logic             err_out
);

    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(N_CMP);

    life_e  life_q, life_d;
    errst_e err_q,  err_d;

    logic [BIN_W-1:0] bin_q;
    logic             ovf_q;

    // State registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            life_q <= LC_WARM;
            err_q  <= EF_CLEAN;
        end else begin
            life_q <= life_d;
            err_q  <= err_d;
        end
    end

    // Transitions: WARM -> LIVE once, CLEAN -> FLAGGED on a strict bubble.
    always_comb begin
        life_d = life_q;
        unique case (life_q)
            LC_WARM: life_d = LC_LIVE;
            LC_LIVE: life_d = LC_LIVE;
        endcase
    end

    always_comb begin
        err_d = err_q;
        unique case (err_q)
            EF_CLEAN:   err_d = bubble_hit ? EF_FLAGGED : EF_CLEAN;
            EF_FLAGGED: err_d = EF_FLAGGED;
        endcase
    end

    // Result register: a full-scale level wraps to zero with overflow.
    always_ff @(posedge clk) begin
        if (rst) begin
            bin_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= (level == FULL_LVL);
            bin_q <= (level == FULL_LVL) ? '0 : level[BIN_W-1:0];
        end
    end

    // Outputs.
    always_comb begin
        bin_out   = bin_q;
        ovf_out   = ovf_q;
        valid_out = (life_q == LC_LIVE);
        err_out   = (err_q == EF_FLAGGED);
    end

endmodule

// File: rtl/flash_therm_enc.sv
module flash_therm_enc
    import fte_pkg::*;
#(
    parameter int N_CMP = 8,
    parameter int BIN_W = $clog2(N_CMP)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_CMP-1:0] therm_in,
    input  logic             enc_mode,
    output logic [BIN_W-1:0] bin_out,
    output logic             ovf_out,
    output logic             valid_out,
    output logic             bubble_err
);

    localparam int LVL_W = $clog2(N_CMP + 1);

    logic [N_CMP-1:0] code_q;
    enc_mode_e        mode_q;
    logic [LVL_W-1:0] level;
    logic             bubble_hit;

    fte_capture #(
        .N_CMP (N_CMP)
    ) u_capture (
        .clk      (clk),
        .rst      (rst),
        .therm_in (therm_in),
        .mode_in  (enc_mode),
        .code_q   (code_q),
        .mode_q   (mode_q)
    );

    fte_level_enc #(
        .N_CMP (N_CMP),
        .LVL_W (LVL_W)
    ) u_level (
        .code       (code_q),
        .mode       (mode_q),
        .level      (level),
        .bubble_hit (bubble_hit)
    );

    fte_out_stage #(
        .N_CMP (N_CMP),
        .BIN_W (BIN_W),
        .LVL_W (LVL_W)
    ) u_out (
        .clk        (clk),
        .rst        (rst),
        .level      (level),
        .bubble_hit (bubble_hit),
        .bin_out    (bin_out),
        .ovf_out    (ovf_out),
        .valid_out  (valid_out),
        .err_out    (bubble_err)
    );

endmodule

// File: rtl/fte_checker.sv
module fte_checker #(
    parameter int N_CMP = 8,
    parameter int BIN_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [N_CMP-1:0] therm_in,
    input logic             enc_mode,
    input logic [BIN_W-1:0] bin_out,
    input logic             ovf_out,
    input logic             valid_out,
    input logic             bubble_err
);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (bin_out == '0 && !ovf_out && !valid_out && !bubble_err));

    a_r2_valid_rise: assert property (@(posedge clk)
        $fell(rst) |=> valid_out);

    a_r2_valid_hold: assert property (@(posedge clk) disable iff (rst)
        valid_out |=> valid_out);

    a_r3_full_scale_latency: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $past(therm_in, 2) == '1) |-> ovf_out);

    a_r5_ovf_wraps_zero: assert property (@(posedge clk) disable iff (rst)
        ovf_out |-> (bin_out == '0));

    a_r6_count_no_ovf_with_zero: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && !$past(enc_mode, 2) && $past(therm_in, 2) != '1)
        |-> !ovf_out);

    a_r7_strict_top_bit: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $past(enc_mode, 2) && $past(therm_in[N_CMP-1], 2))
        |-> ovf_out);

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        bubble_err |=> bubble_err);

    a_r9_err_only_strict: assert property (@(posedge clk) disable iff (rst)
        $rose(bubble_err) |-> $past(enc_mode, 2));

endmodule

bind flash_therm_enc fte_checker #(
    .N_CMP (N_CMP),
    .BIN_W (BIN_W)
) u_fte_chk (
    .clk        (clk),
    .rst        (rst),
    .therm_in   (therm_in),
    .enc_mode   (enc_mode),
    .bin_out    (bin_out),
    .ovf_out    (ovf_out),
    .valid_out  (valid_out),
    .bubble_err (bubble_err)
);

// File: tb/test_flash_therm_enc.sv
`timescale 1ns/1ps
module test_flash_therm_enc;

    localparam int N  = 8;
    localparam int BW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  therm = '0;
    logic          mode = 1'b0;
    logic [BW-1:0] bin_out;
    logic          ovf_out;
    logic          valid_out;
    logic          bubble_err;

    always #2.5 clk = ~clk;

    flash_therm_enc i_flash_therm_enc (
        .clk        (clk),
        .rst        (rst),
        .therm_in   (therm),
        .enc_mode   (mode),
        .bin_out    (bin_out),
        .ovf_out    (ovf_out),
        .valid_out  (valid_out),
        .bubble_err (bubble_err)
    );

    typedef struct {
        int            due;
        logic [BW-1:0] bin;
        logic          ovf;
        logic          err;
        string         tag;
    } exp_t;

    exp_t sb[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   model_err = 1'b0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Reference model, written from the requirements.
    function automatic int ref_level(logic [N-1:0] c, bit strict);
        int n = 0;
        if (strict) begin
            for (int i = N - 1; i >= 0; i--) if (c[i]) return i + 1;
            return 0;
        end
        for (int i = 0; i < N; i++) n += int'(c[i]);
        return n;
    endfunction

    function automatic bit has_hole(logic [N-1:0] c);
        for (int i = 1; i < N; i++) if (c[i] && !c[i-1]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Driver: one word per cycle, expected result queued for two edges later.
    task automatic send(logic [N-1:0] c, bit strict, string tag);
        exp_t e;
        int   lvl;
        @(negedge clk);
        #0.5;
        therm = c;
        mode  = strict;
        lvl   = ref_level(c, strict);
        if (strict && has_hole(c)) model_err = 1'b1;
        e.due = cyc + 2;
        e.ovf = (lvl == N);
        e.bin = (lvl == N) ? '0 : BW'(lvl);
        e.err = model_err;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare at the falling edge in the cycle the result is due.
    always @(negedge clk) begin
        if (!rst && sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            e = sb.pop_front();
            chk({e.tag, " bin"},   int'(bin_out),    int'(e.bin));
            chk({e.tag, " ovf"},   int'(ovf_out),    int'(e.ovf));
            chk({e.tag, " R8 err"}, int'(bubble_err), int'(e.err));
            chk({e.tag, " R2 valid"}, int'(valid_out), 1);
        end
    end

    task automatic drain();
        repeat (4) @(negedge clk);
        chk("R3 queue drained", sb.size(), 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        #0.5;
        rst   = 1'b1;
        therm = '0;
        mode  = 1'b0;
        repeat (3) @(negedge clk);
        sb.delete();
        model_err = 1'b0;
        chk("R1 bin",   int'(bin_out),    0);
        chk("R1 ovf",   int'(ovf_out),    0);
        chk("R1 err",   int'(bubble_err), 0);
        chk("R1 valid", int'(valid_out),  0);
        #0.5;
        rst = 1'b0;
        @(negedge clk);
        chk("R2 valid after release", int'(valid_out), 1);
    endtask

    initial begin
        do_reset();

        // R4 / R5: every proper thermometer word, both modes.
        for (int m = 0; m < 2; m++) begin
            for (int n = 0; n <= N; n++) begin
                logic [N-1:0] c;
                c = (n == N) ? '1 : N'((1 << n) - 1);
                send(c, m[0], (n == N) ? "R3 R5 full scale" : "R3 R4 proper word");
            end
        end
        drain();

        // R6 / R9: bubbled words in counting mode never raise the flag.
        for (int k = 0; k < 40; k++) begin
            send(N'($urandom), 1'b0, "R6 R9 count bubbled");
        end
        send('1, 1'b0, "R5 R6 count full");
        drain();
        chk("R9 err untouched by count mode", int'(bubble_err), 0);

        // R7 / R8: overflow and bubble flag in the same cycle, then stickiness.
        send(8'b1011_1111, 1'b1, "R7 R8 strict top bit with hole");
        send(8'b0000_0111, 1'b1, "R8 sticky after proper word");
        send(8'b0000_0000, 1'b0, "R8 sticky in count mode");
        for (int k = 0; k < 40; k++) begin
            send(N'($urandom), 1'b1, "R7 strict random");
        end
        drain();

        // R8: reset clears the flag.
        do_reset();
        chk("R8 err cleared by reset", int'(bubble_err), 0);

        // R10: same bubbled word, mode flipped each cycle.
        send(8'b0000_0011, 1'b0, "R10 warmup");
        for (int k = 0; k < 6; k++) begin
            send(8'b0010_1101, k[0], "R10 R6 R7 alternating mode");
        end
        send(8'b1000_0001, 1'b0, "R10 count two ones");
        send(8'b1000_0001, 1'b1, "R10 R7 strict top");
        drain();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R3 watchdog act=%0d exp=done", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule